// File: doc/BRIEF.md
# Fixed-Priority Vectored Interrupt Controller

This block sits beside a small 8-bit processor core and decides which of five hardware interrupt lines gets served next. The lines are, from highest to lowest priority: a non-maskable line (TRAP), an edge-latched line (R75), two level-sensed lines (R65, R55) and a non-vectored line (INTR). Each line has its own trigger rule. A global enable flip-flop gates every line except TRAP. R75, R65 and R55 also have individual mask bits.

The core raises `eoi_strobe` for one cycle at its instruction-boundary sampling point. On that clock edge the controller picks a single winner. One cycle later it presents the winner's identity and 16-bit service address. The INTR line has no fixed address. For INTR the controller drives `inta_n` low for one cycle, reads a restart opcode from `dbus_in`, and presents the derived address one cycle after that.

Software reaches the enable flip-flop and the masks through a four-operation command port: enable, disable, set-mask and read-mask.

Top module: `prio_irq_ctrl`

## Requirements
- R1: After reset, `grant_valid` is 0, `inta_n` is 1, all masks are clear, both edge latches are empty and the global enable is 0. A read-mask issued with all lines low returns 0x00.
- R2: Only one request is granted per sampling point. Priority from highest to lowest is TRAP, R75, R65, R55, INTR. `grant_id` encodes them as 0, 1, 2, 3 and 4 respectively.
- R3: The fixed service addresses are TRAP 0x0024, R75 0x003C, R65 0x0034 and R55 0x002C.
- R4: TRAP ignores the masks and the global enable. It is granted only when a rising edge was registered at a clock edge before the sampling edge and the line is still high at sampling. After a grant, a line that stays high is not granted again until a new rising edge.
- R5: A rising edge on R75 sets a pending latch. The latch holds after the line falls. It is cleared when R75 is granted, or by a set-mask write with bit 4 set.
- R6: R65, R55 and INTR count only when the line is high at the sampling edge.
- R7: Requests are sampled only on clock edges where `eoi_strobe` is 1. A vectored grant is shown on `grant_valid`, `grant_id` and `grant_addr` for exactly the one cycle that follows that edge.
- R8: Command op 0 sets the global enable and op 1 clears it. While the enable is clear, nothing but TRAP is granted. Granting any request other than TRAP clears the enable.
- R9: Command op 2 (set-mask) takes `cmd_wdata`. Bit 3 set loads the masks from bits [2:0]: bit 0 masks R55, bit 1 masks R65, bit 2 masks R75, and a 1 means blocked. Bit 4 set empties the R75 latch.
- R10: Command op 3 (read-mask) updates `rd_data` one cycle later with: [2:0] masks, [3] global enable, [4] R55 level, [5] R65 level, [6] R75 latch, [7] 0.
- R11: When INTR wins, `inta_n` is low for exactly the cycle after the sampling edge. At the next edge the controller takes the opcode from `dbus_in` and shows a grant with id 4 and address opcode[5:3]×8 (0x0000..0x0038). Sampling edges that fall during that low cycle are ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| trap_in | input | 1 | Non-maskable line, needs an edge and a held level |
| r75_in | input | 1 | Edge-latched maskable line |
| r65_in | input | 1 | Level-sensed maskable line |
| r55_in | input | 1 | Level-sensed maskable line |
| intr_in | input | 1 | Level-sensed non-vectored line |
| eoi_strobe | input | 1 | Instruction-boundary sampling strobe from the core |
| cmd_valid | input | 1 | Command strobe |
| cmd_op | input | 2 | 0 enable, 1 disable, 2 set-mask, 3 read-mask |
| cmd_wdata | input | 8 | Set-mask value |
| rd_data | output | 8 | Read-mask result |
| dbus_in | input | 8 | Data bus carrying the restart opcode during acknowledge |
| inta_n | output | 1 | Active-low acknowledge for INTR |
| grant_valid | output | 1 | One-cycle grant pulse |
| grant_id | output | 3 | Index of the granted line |
| grant_addr | output | 16 | Service address of the granted line |

## Verification
A vectored grant is due in the cycle right after the `eoi_strobe` edge. An INTR grant is due one cycle later: `inta_n` is low in between, and the opcode is read at that edge. Read-mask data is due one cycle after the command. The bench drives every input on a falling edge and reads each result on the falling edge that follows the rising edge that produces it, so every check lands mid-cycle inside the single cycle where the result is valid. Edge-triggered lines are raised at least one full cycle before the strobe, so the latch is set before the sampling edge.

// File: rtl/prio_irq_pkg.sv
package prio_irq_pkg;
  localparam int NSRC = 5;
  localparam int IDW  = $clog2(NSRC);

  typedef enum logic [2:0] {
    SRC_TRAP = 3'd0,
    SRC_R75  = 3'd1,
    SRC_R65  = 3'd2,
    SRC_R55  = 3'd3,
    SRC_INTR = 3'd4
  } src_e;

  typedef enum logic [1:0] {
    CMD_EN   = 2'd0,
    CMD_DIS  = 2'd1,
    CMD_SETM = 2'd2,
    CMD_RDM  = 2'd3
  } cmd_e;

  // fixed service address per vectored source
  function automatic logic [15:0] vec_of(input src_e s);
    case (s)
      SRC_TRAP: vec_of = 16'h0024;
      SRC_R75:  vec_of = 16'h003C;
      SRC_R65:  vec_of = 16'h0034;
      SRC_R55:  vec_of = 16'h002C;
      default:  vec_of = 16'h0000;
    endcase
  endfunction
endpackage

// File: rtl/irq_edge_latch.sv
module irq_edge_latch (
  input  logic clk,
  input  logic rst,
  input  logic din,
  input  logic clr,
  output logic pend
);
  logic prev_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      prev_q <= 1'b0;
      pend   <= 1'b0;
    end else begin
      prev_q <= din;
      if (din && !prev_q) pend <= 1'b1;   // a fresh edge wins over a clear
      else if (clr)       pend <= 1'b0;
    end
  end
endmodule

// File: rtl/irq_prio_pick.sv
module irq_prio_pick #(
  parameter int N  = 5,
  localparam int IW = $clog2(N)
) (
  input  logic [N-1:0]  req,
  output logic          any,
  output logic [IW-1:0] idx
);
  // bit 0 is the highest priority
  always_comb begin
    any = |req;
    idx = '0;
    for (int i = N - 1; i >= 0; i--) begin
      if (req[i]) idx = IW'(i);
    end
  end
endmodule

// File: rtl/irq_ack_seq.sv
module irq_ack_seq (
  input  logic clk,
  input  logic rst,
  input  logic start,
  output logic busy,
  output logic inta_n
);
  logic busy_q;

  always_ff @(posedge clk) begin
    if (rst)         busy_q <= 1'b0;
    else if (busy_q) busy_q <= 1'b0;
    else             busy_q <= start;
  end

  assign busy   = busy_q;
  assign inta_n = ~busy_q;
endmodule

// File: rtl/prio_irq_ctrl.sv
module prio_irq_ctrl
  import prio_irq_pkg::*;
#(
  parameter int DW = 8,
  parameter int AW = 16
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          trap_in,
  input  logic          r75_in,
  input  logic          r65_in,
  input  logic          r55_in,
  input  logic          intr_in,
  input  logic          eoi_strobe,
  input  logic          cmd_valid,
  input  logic [1:0]    cmd_op,
  input  logic [DW-1:0] cmd_wdata,
  output logic [DW-1:0] rd_data,
  input  logic [DW-1:0] dbus_in,
  output logic          inta_n,
  output logic          grant_valid,
  output logic [2:0]    grant_id,
  output logic [AW-1:0] grant_addr
);
  localparam int NMASK = 3;

  logic             ie_q;
  logic [NMASK-1:0] mask_q;      // [0] R55, [1] R65, [2] R75
  logic             trap_pend, r75_pend;
  logic             trap_clr, r75_clr;
  logic [NSRC-1:0]  req;
  logic             pick_any;
  logic [IDW-1:0]   pick_idx;
  logic             ack_busy, ack_start, take;
  logic             setm_cmd;

  assign setm_cmd = cmd_valid && (cmd_op == CMD_SETM);
  assign take     = eoi_strobe && !ack_busy && pick_any;
  assign trap_clr = take && (pick_idx == IDW'(SRC_TRAP));
  assign r75_clr  = (take && (pick_idx == IDW'(SRC_R75))) || (setm_cmd && cmd_wdata[4]);
  assign ack_start = take && (pick_idx == IDW'(SRC_INTR));

  irq_edge_latch u_trap_lat (
    .clk(clk), .rst(rst), .din(trap_in), .clr(trap_clr), .pend(trap_pend)
  );

  irq_edge_latch u_r75_lat (
    .clk(clk), .rst(rst), .din(r75_in), .clr(r75_clr), .pend(r75_pend)
  );

  always_comb begin
    req           = '0;
    req[SRC_TRAP] = trap_pend && trap_in;
    req[SRC_R75]  = ie_q && !mask_q[2] && r75_pend;
    req[SRC_R65]  = ie_q && !mask_q[1] && r65_in;
    req[SRC_R55]  = ie_q && !mask_q[0] && r55_in;
    req[SRC_INTR] = ie_q && intr_in;
  end

  irq_prio_pick #(.N(NSRC)) u_pick (
    .req(req), .any(pick_any), .idx(pick_idx)
  );

  irq_ack_seq u_ack (
    .clk(clk), .rst(rst), .start(ack_start), .busy(ack_busy), .inta_n(inta_n)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      ie_q        <= 1'b0;
      mask_q      <= '0;
      rd_data     <= '0;
      grant_valid <= 1'b0;
      grant_id    <= 3'd0;
      grant_addr  <= '0;
    end else begin
      grant_valid <= 1'b0;
      if (cmd_valid) begin
        case (cmd_op)
          CMD_EN:  ie_q <= 1'b1;
          CMD_DIS: ie_q <= 1'b0;
          CMD_SETM: if (cmd_wdata[3]) mask_q <= cmd_wdata[NMASK-1:0];
          default: rd_data <= DW'({1'b0, r75_pend, r65_in, r55_in, ie_q, mask_q});
        endcase
      end
      if (take) begin
        if (pick_idx != IDW'(SRC_TRAP)) ie_q <= 1'b0;   // acceptance overrides a command
        if (pick_idx != IDW'(SRC_INTR)) begin
          grant_valid <= 1'b1;
          grant_id    <= 3'(pick_idx);
          grant_addr  <= AW'(vec_of(src_e'(pick_idx)));
        end
      end
      if (ack_busy) begin
        grant_valid <= 1'b1;
        grant_id    <= SRC_INTR;
        grant_addr  <= AW'({dbus_in[5:3], 3'b000});
      end
    end
  end
endmodule

// File: rtl/prio_irq_chk.sv
module prio_irq_chk
  import prio_irq_pkg::*;
#(
  parameter int AW = 16
) (
  input logic          clk,
  input logic          rst,
  input logic          trap_in,
  input logic          eoi_strobe,
  input logic          inta_n,
  input logic          grant_valid,
  input logic [2:0]    grant_id,
  input logic [AW-1:0] grant_addr,
  input logic          ie,
  input logic [2:0]    mask
);
  assert_trap_level_R4: assert property (@(posedge clk) disable iff (rst)
    grant_valid && grant_id == SRC_TRAP |-> $past(trap_in));

  assert_r75_vector_R3: assert property (@(posedge clk) disable iff (rst)
    grant_valid && grant_id == SRC_R75 |-> grant_addr == AW'(16'h003C));

  assert_sample_at_eoi_R7: assert property (@(posedge clk) disable iff (rst)
    grant_valid && grant_id != SRC_INTR |-> $past(eoi_strobe));

  assert_ie_cleared_R8: assert property (@(posedge clk) disable iff (rst)
    grant_valid && grant_id != SRC_TRAP && grant_id != SRC_INTR |-> !ie);

  assert_ie_gate_R8: assert property (@(posedge clk) disable iff (rst)
    grant_valid && grant_id == SRC_R65 |-> $past(ie));

  assert_r55_mask_R9: assert property (@(posedge clk) disable iff (rst)
    grant_valid && grant_id == SRC_R55 |-> !$past(mask[0]));

  assert_ack_single_R11: assert property (@(posedge clk) disable iff (rst)
    !inta_n |=> inta_n);

  assert_ack_grant_R11: assert property (@(posedge clk) disable iff (rst)
    !inta_n |=> grant_valid && grant_id == SRC_INTR);

  assert_one_id_R2: assert property (@(posedge clk) disable iff (rst)
    grant_valid |-> grant_id <= 3'd4);
endmodule

bind prio_irq_ctrl prio_irq_chk #(.AW(AW)) u_chk (
  .clk(clk), .rst(rst), .trap_in(trap_in), .eoi_strobe(eoi_strobe),
  .inta_n(inta_n), .grant_valid(grant_valid), .grant_id(grant_id),
  .grant_addr(grant_addr), .ie(ie_q), .mask(mask_q)
);

// File: tb/sim_prio_irq_ctrl.sv
module sim_prio_irq_ctrl;
  localparam int CLK_PERIOD = 10;

  logic        clk = 0, rst = 1;
  logic        trap_in = 0, r75_in = 0, r65_in = 0, r55_in = 0, intr_in = 0;
  logic        eoi_strobe = 0, cmd_valid = 0;
  logic [1:0]  cmd_op = 0;
  logic [7:0]  cmd_wdata = 0, dbus_in = 0;
  logic [7:0]  rd_data;
  logic        inta_n, grant_valid;
  logic [2:0]  grant_id;
  logic [15:0] grant_addr;

  int n_run = 0, n_fail = 0;

  always #(CLK_PERIOD / 2) clk = ~clk;

  prio_irq_ctrl u0 (
    .clk(clk), .rst(rst), .trap_in(trap_in), .r75_in(r75_in), .r65_in(r65_in),
    .r55_in(r55_in), .intr_in(intr_in), .eoi_strobe(eoi_strobe),
    .cmd_valid(cmd_valid), .cmd_op(cmd_op), .cmd_wdata(cmd_wdata),
    .rd_data(rd_data), .dbus_in(dbus_in), .inta_n(inta_n),
    .grant_valid(grant_valid), .grant_id(grant_id), .grant_addr(grant_addr)
  );

  task automatic chk(input bit ok, input string rq, input int act, input int exp);
    n_run++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=0x%0h expected=0x%0h", rq, act, exp);
    end
  endtask

  task automatic tick(); @(negedge clk); endtask

  task automatic cmd(input logic [1:0] op, input logic [7:0] wd);
    cmd_valid = 1; cmd_op = op; cmd_wdata = wd;
    tick();
    cmd_valid = 0; cmd_wdata = 0;
  endtask

  task automatic eoi();
    eoi_strobe = 1;
    tick();
    eoi_strobe = 0;
  endtask

  // expects a vectored grant (id<4) or none (id==7) right after eoi
  task automatic expect_grant(input int id, input string rq);
    if (id == 7) chk(!grant_valid, rq, grant_valid, 0);
    else begin
      chk(grant_valid && grant_id == 3'(id), rq, {grant_valid, grant_id}, 8 + id);
      chk(grant_addr == vaddr(id), {rq, " R3"}, grant_addr, vaddr(id));
    end
  endtask

  function automatic int vaddr(input int id);
    case (id)
      0: return 'h24;
      1: return 'h3C;
      2: return 'h34;
      3: return 'h2C;
      default: return 0;
    endcase
  endfunction

  initial begin
    tick(); tick(); tick();
    rst = 0;
    tick();
    // R1 reset state
    chk(!grant_valid && inta_n, "R1", {grant_valid, inta_n}, 1);
    cmd(2'd3, 0);
    chk(rd_data == 8'h00, "R1", rd_data, 0);

    // R7: no sampling without the strobe, then R6 level grant
    cmd(2'd0, 0);
    r55_in = 1;
    for (int k = 0; k < 3; k++) begin
      tick();
      chk(!grant_valid, "R7", grant_valid, 0);
    end
    eoi();
    expect_grant(3, "R6");
    r55_in = 0;

    // R4: TRAP ignores masks and enable
    cmd(2'd2, 8'h0F);
    cmd(2'd1, 0);
    trap_in = 1; tick(); tick();
    eoi();
    expect_grant(0, "R4");
    tick();
    eoi();
    expect_grant(7, "R4 held level no new edge");
    trap_in = 0; tick();
    trap_in = 1; tick();
    trap_in = 0; tick();
    eoi();
    expect_grant(7, "R4 edge without level");
    trap_in = 1; tick();
    eoi();
    expect_grant(0, "R4 edge+level");
    trap_in = 0;
    cmd(2'd2, 8'h08);

    // R8: enable gates maskable requests, grant clears it
    r65_in = 1; tick();
    eoi();
    expect_grant(7, "R8 disabled");
    cmd(2'd0, 0);
    eoi();
    expect_grant(2, "R8 enabled");
    tick();
    eoi();
    expect_grant(7, "R8 cleared by grant");
    r65_in = 0;

    // R5: latch holds after line falls
    r75_in = 1; tick(); r75_in = 0; tick();
    cmd(2'd3, 0);
    chk(rd_data[6] == 1'b1, "R5 latch", rd_data, 8'h40);
    cmd(2'd0, 0);
    eoi();
    expect_grant(1, "R5");
    cmd(2'd3, 0);
    chk(rd_data == 8'h00, "R5 cleared", rd_data, 0);

    // R2 priority: TRAP beats everything, then R75
    cmd(2'd0, 0);
    trap_in = 1; r75_in = 1; r65_in = 1; r55_in = 1; intr_in = 1; tick(); tick();
    eoi();
    expect_grant(0, "R2");
    eoi();
    expect_grant(1, "R2");
    trap_in = 0; r75_in = 0; r65_in = 0; r55_in = 0; intr_in = 0;

    // near-exhaustive sweep over masks and line patterns
    for (int c = 0; c < 128; c++) begin
      automatic logic [2:0] m = c[2:0];
      automatic bit p75 = c[3], l65 = c[4], l55 = c[5], li = c[6];
      automatic int w = 7;
      automatic int rn = c % 8;
      cmd(2'd2, {3'b000, 2'b11, m});
      cmd(2'd3, 0);
      chk(rd_data[2:0] == m && rd_data[6:4] == 0, "R9", rd_data, m);
      cmd(2'd0, 0);
      if (p75) begin r75_in = 1; tick(); r75_in = 0; end
      r65_in = l65; r55_in = l55; intr_in = li;
      tick();
      if (li) w = 4;
      if (l55 && !m[0]) w = 3;
      if (l65 && !m[1]) w = 2;
      if (p75 && !m[2]) w = 1;
      eoi();
      if (w == 4) begin
        chk(!grant_valid && !inta_n, "R11 ack", {grant_valid, inta_n}, 0);
        dbus_in = {2'b11, 3'(rn), 3'b111};
        tick();
        dbus_in = 0;
        chk(grant_valid && grant_id == 3'd4 && grant_addr == 16'(rn * 8) && inta_n,
            "R11 grant", grant_addr, rn * 8);
      end else begin
        expect_grant(w, "R2 sweep");
        chk(inta_n, "R11 idle", inta_n, 1);
      end
      r65_in = 0; r55_in = 0; intr_in = 0;
      cmd(2'd3, 0);
      chk(rd_data[3] == (w == 7) && rd_data[6] == (p75 && w != 1), "R10",
          rd_data, {(p75 && w != 1), 3'b000, (w == 7), m});
    end

    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog expired");
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule